// File: doc/BRIEF.md
# Masked Configuration Register File

This block holds the configuration space of a peripheral function: an array of 32-bit dwords addressed by dword index for reads and by byte address for writes. Each dword carries a writable-bit mask. A write of any size only changes bits that are both writable and inside the addressed byte lanes. Identity words, class words, the interrupt pin and the reset interrupt line come from parameters. A header-kind parameter chooses between an endpoint mask layout and a bridge mask layout.

Only the dwords that have writable bits hold storage. Every other dword inside the range reads as a constant. A sideband input marks that a capability structure is present by setting a sticky status bit. A write port carries valid, byte address, size code and data. A read port takes an index each cycle and returns the addressed word one cycle later.

Top module: `cfg_space_regfile`

## Requirements
- R1: After reset, dword 0 reads {DEVICE_ID, VENDOR_ID}. Dword 2 reads {CLASS_CODE, SUBCLASS, PROG_IF, REVISION}, the most significant byte first. Dword 11 reads {SUBSYS_ID, SUBSYS_VENDOR}. None of these three can be written.
- R2: `rd_data` shows the word addressed by the `rd_idx` value sampled at the previous rising clock edge. An index of NUM_DWORDS or above returns 0xFFFFFFFF.
- R3: The `wr_size` code is 0 for a byte, 1 for 16 bits, 2 for a full dword and 3 for a dropped write. A full dword write with byte offset 0 sets the word to (old & ~mask) | (data & mask). A full dword write with a nonzero byte offset is dropped.
- R4: In dword 1, bits 15:0 (command) are writable. Bits 31:16 (status) cannot be changed by any write.
- R5: A high `cap_present` at a rising edge sets bit 20 of dword 1. The bit then stays set until reset and is unaffected by writes.
- R6: In dword 3, bits 7:0 are writable. Bits 23:16 read 0x00 for an endpoint and 0x01 for a bridge, and cannot be written.
- R7: A 16-bit write takes its data from `wr_data[15:0]`. It is applied only at byte offset 0 (bits 15:0) or byte offset 2 (bits 31:16). At offset 1 or 3 it is dropped.
- R8: A byte write takes its data from `wr_data[7:0]` and places it in lane (offset × 8). It changes only the writable bits of that lane.
- R9: Dword 15 resets to {16'h0, INT_PIN+1, INT_LINE}. Bits 15:8 (the pin) cannot be written. The mask is 0x000000FF for an endpoint and 0xFFFF00FF for a bridge.
- R10: For a bridge, dword 9 has the mask 0xFFF0FFF0. For an endpoint, dword 9 reads 0 and ignores writes.
- R11: A write whose dword index is NUM_DWORDS or above changes no register. It raises `wr_err` for exactly the one cycle after its clock edge. Any other cycle leaves `wr_err` low.
- R12: A synchronous active-high `rst` restores every stored dword to its parameter value and clears the capability bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_present | input | 1 | Sets the capability status bit |
| wr_valid | input | 1 | Write request this cycle |
| wr_addr | input | IDX_W+3 | Byte address of the write |
| wr_size | input | 2 | 0 byte, 1 half, 2 full, 3 dropped |
| wr_data | input | 32 | Write data, low-aligned for sub-dword writes |
| wr_err | output | 1 | One-cycle flag for a write beyond the array |
| rd_idx | input | IDX_W+1 | Dword index to read |
| rd_data | output | 32 | Word read at the previous edge |

## Verification
A write is applied at the clock edge where `wr_valid` is high. A read index is sampled at an edge and its word appears right after that edge. The earliest moment a written value can be observed is therefore a read index sampled at the next edge, and the bench drives its reads that way. `wr_err` belongs to the cycle straight after the offending edge, so the bench samples it in that cycle and again one cycle later to confirm it dropped. All inputs change on the falling edge and all outputs are sampled on the falling edge. This keeps each check exactly one register stage from its stimulus. The endpoint and bridge variants share their inputs, so every stimulus checks both mask layouts at once.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_FULL = 2'd2,
      SZ_NONE = 2'd3
   } wr_size_e;

   typedef enum logic {
      HDR_ENDPOINT = 1'b0,
      HDR_BRIDGE   = 1'b1
   } hdr_kind_e;

   // fixed header positions decoded by host software
   localparam int IDX_IDENT   = 0;
   localparam int IDX_CMDSTAT = 1;
   localparam int IDX_CLASS   = 2;
   localparam int IDX_HDR     = 3;
   localparam int IDX_WINDOW  = 9;
   localparam int IDX_SUBSYS  = 11;
   localparam int IDX_IRQ     = 15;
   localparam int MIN_DWORDS  = 16;

   localparam logic [31:0] CAP_BIT = 32'h0010_0000;

   // dwords that may own storage
   localparam int NUM_SLOTS = 4;

   function automatic int slot_index(input int s);
      case (s)
         0:       return IDX_CMDSTAT;
         1:       return IDX_HDR;
         2:       return IDX_WINDOW;
         default: return IDX_IRQ;
      endcase
   endfunction

   function automatic logic [31:0] slot_wmask(input int s, input hdr_kind_e h);
      case (s)
         0:       return 32'h0000_FFFF;
         1:       return 32'h0000_00FF;
         2:       return (h == HDR_BRIDGE) ? 32'hFFF0_FFF0 : 32'h0000_0000;
         default: return (h == HDR_BRIDGE) ? 32'hFFFF_00FF : 32'h0000_00FF;
      endcase
   endfunction

endpackage

// File: rtl/cfg_wr_align.sv
module cfg_wr_align
   import cfgspace_pkg::*;
#(
   parameter int NUM_DWORDS = 1024,
   parameter int IDX_W      = 10,
   parameter int AW         = IDX_W + 3
) (
   input  logic             wr_valid,
   input  logic [AW-1:0]    wr_addr,
   input  logic [1:0]       wr_size,
   input  logic [31:0]      wr_data,
   output logic [IDX_W-1:0] wr_idx,
   output logic [31:0]      lane_mask,
   output logic [31:0]      lane_data,
   output logic             wr_go,
   output logic             wr_oob
);
   localparam int FW = AW - 2;
   localparam logic [FW-1:0] LIMIT = FW'(NUM_DWORDS);

   logic [FW-1:0] full_idx;
   logic [1:0]    off;
   logic          in_range;
   logic          shape_ok;

   assign full_idx = wr_addr[AW-1:2];
   assign off      = wr_addr[1:0];
   assign in_range = full_idx < LIMIT;
   assign wr_idx   = full_idx[IDX_W-1:0];

   always_comb begin
      lane_mask = '0;
      lane_data = '0;
      shape_ok  = 1'b0;
      case (wr_size_e'(wr_size))
         SZ_BYTE: begin
            shape_ok  = 1'b1;
            lane_mask = 32'h0000_00FF << {off, 3'b000};
            lane_data = {24'h0, wr_data[7:0]} << {off, 3'b000};
         end
         SZ_HALF: begin
            shape_ok  = ~off[0];
            lane_mask = 32'h0000_FFFF << {off[1], 4'b0000};
            lane_data = {16'h0, wr_data[15:0]} << {off[1], 4'b0000};
         end
         SZ_FULL: begin
            shape_ok  = (off == 2'b00);
            lane_mask = 32'hFFFF_FFFF;
            lane_data = wr_data;
         end
         default: shape_ok = 1'b0;
      endcase
   end

   assign wr_go  = wr_valid & in_range & shape_ok;
   assign wr_oob = wr_valid & ~in_range;
endmodule

// File: rtl/cfg_reg_slot.sv
module cfg_reg_slot #(
   parameter logic [31:0] RESET_VAL = 32'h0,
   parameter logic [31:0] WMASK     = 32'h0,
   parameter logic [31:0] SET_BITS  = 32'h0
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        wr_en,
   input  logic [31:0] lane_mask,
   input  logic [31:0] lane_data,
   input  logic        set_req,
   output logic [31:0] q
);
   logic [31:0] hit;
   logic [31:0] nxt;

   assign hit = WMASK & lane_mask;

   always_comb begin
      nxt = q;
      if (wr_en) nxt = (q & ~hit) | (lane_data & hit);
      if (set_req) nxt = nxt | SET_BITS;
   end

   always_ff @(posedge clk) begin
      if (rst) q <= RESET_VAL;
      else     q <= nxt;
   end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
   import cfgspace_pkg::*;
#(
   parameter int          NUM_DWORDS  = 1024,
   parameter int          RIW         = 11,
   parameter logic [31:0] IDENT_WORD  = 32'h0,
   parameter logic [31:0] CLASS_WORD  = 32'h0,
   parameter logic [31:0] SUBSYS_WORD = 32'h0
) (
   input  logic [RIW-1:0]            rd_idx,
   input  logic [NUM_SLOTS-1:0][31:0] slot_q,
   output logic [31:0]               rd_word
);
   localparam logic [RIW-1:0] LIMIT = RIW'(NUM_DWORDS);

   always_comb begin
      rd_word = '0;
      if (rd_idx == RIW'(IDX_IDENT))  rd_word = IDENT_WORD;
      if (rd_idx == RIW'(IDX_CLASS))  rd_word = CLASS_WORD;
      if (rd_idx == RIW'(IDX_SUBSYS)) rd_word = SUBSYS_WORD;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (rd_idx == RIW'(slot_index(s))) rd_word = slot_q[s];
      end
      if (rd_idx >= LIMIT) rd_word = '1;
   end
endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile
   import cfgspace_pkg::*;
#(
   parameter int          NUM_DWORDS    = 1024,
   parameter hdr_kind_e   HDR_KIND      = HDR_ENDPOINT,
   parameter logic [15:0] VENDOR_ID     = 16'h0,
   parameter logic [15:0] DEVICE_ID     = 16'h0,
   parameter logic [7:0]  REVISION      = 8'h0,
   parameter logic [7:0]  CLASS_CODE    = 8'h0,
   parameter logic [7:0]  SUBCLASS      = 8'h0,
   parameter logic [7:0]  PROG_IF       = 8'h0,
   parameter logic [15:0] SUBSYS_VENDOR = 16'h0,
   parameter logic [15:0] SUBSYS_ID     = 16'h0,
   parameter int          INT_PIN       = 0,
   parameter logic [7:0]  INT_LINE      = 8'h0,
   localparam int         IDX_W         = $clog2(NUM_DWORDS),
   localparam int         AW            = IDX_W + 3,
   localparam int         RIW           = IDX_W + 1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           cap_present,
   input  logic           wr_valid,
   input  logic [AW-1:0]  wr_addr,
   input  logic [1:0]     wr_size,
   input  logic [31:0]    wr_data,
   output logic           wr_err,
   input  logic [RIW-1:0] rd_idx,
   output logic [31:0]    rd_data
);
   localparam logic [31:0] IDENT_WORD  = {DEVICE_ID, VENDOR_ID};
   localparam logic [31:0] CLASS_WORD  = {CLASS_CODE, SUBCLASS, PROG_IF, REVISION};
   localparam logic [31:0] SUBSYS_WORD = {SUBSYS_ID, SUBSYS_VENDOR};
   localparam logic [7:0]  PIN_CODE    = 8'(INT_PIN + 1);

   function automatic logic [31:0] init_word(input int i);
      case (i)
         IDX_HDR: return (HDR_KIND == HDR_BRIDGE) ? 32'h0001_0000 : 32'h0;
         IDX_IRQ: return {16'h0, PIN_CODE, INT_LINE};
         default: return 32'h0;
      endcase
   endfunction

   if (NUM_DWORDS < MIN_DWORDS) begin : g_bad_depth
      $error("NUM_DWORDS must cover the standard header");
   end
   if (INT_PIN < 0 || INT_PIN > 3) begin : g_bad_pin
      $error("INT_PIN must be 0 to 3");
   end

   logic [IDX_W-1:0]           wr_idx;
   logic [31:0]                lane_mask;
   logic [31:0]                lane_data;
   logic                       wr_go;
   logic                       wr_oob;
   logic [NUM_SLOTS-1:0][31:0] slot_q;
   logic [31:0]                rd_word;

   cfg_wr_align #(
      .NUM_DWORDS(NUM_DWORDS),
      .IDX_W     (IDX_W),
      .AW        (AW)
   ) u_align (
      .wr_valid (wr_valid),
      .wr_addr  (wr_addr),
      .wr_size  (wr_size),
      .wr_data  (wr_data),
      .wr_idx   (wr_idx),
      .lane_mask(lane_mask),
      .lane_data(lane_data),
      .wr_go    (wr_go),
      .wr_oob   (wr_oob)
   );

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      localparam int          SIDX = slot_index(s);
      localparam logic [31:0] SWM  = slot_wmask(s, HDR_KIND);
      localparam logic [31:0] SRV  = init_word(SIDX);
      localparam logic [31:0] SSET = (SIDX == IDX_CMDSTAT) ? CAP_BIT : 32'h0;
      if (SWM != 32'h0 || SSET != 32'h0) begin : g_store
         cfg_reg_slot #(
            .RESET_VAL(SRV),
            .WMASK    (SWM),
            .SET_BITS (SSET)
         ) u_slot (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_go && (wr_idx == IDX_W'(SIDX))),
            .lane_mask(lane_mask),
            .lane_data(lane_data),
            .set_req  (cap_present),
            .q        (slot_q[s])
         );
      end else begin : g_const
         assign slot_q[s] = SRV;
      end
   end

   cfg_read_mux #(
      .NUM_DWORDS (NUM_DWORDS),
      .RIW        (RIW),
      .IDENT_WORD (IDENT_WORD),
      .CLASS_WORD (CLASS_WORD),
      .SUBSYS_WORD(SUBSYS_WORD)
   ) u_rmux (
      .rd_idx (rd_idx),
      .slot_q (slot_q),
      .rd_word(rd_word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_data <= '0;
         wr_err  <= 1'b0;
      end else begin
         rd_data <= rd_word;
         wr_err  <= wr_oob;
      end
   end
endmodule

// File: rtl/cfg_space_checker.sv
module cfg_space_checker #(
   parameter int          NUM_DWORDS = 1024,
   parameter logic [15:0] VENDOR_ID  = 16'h0,
   parameter logic [15:0] DEVICE_ID  = 16'h0,
   localparam int         IDX_W      = $clog2(NUM_DWORDS),
   localparam int         AW         = IDX_W + 3,
   localparam int         RIW        = IDX_W + 1
) (
   input logic           clk,
   input logic           rst,
   input logic           cap_present,
   input logic           wr_valid,
   input logic [AW-1:0]  wr_addr,
   input logic           wr_err,
   input logic [RIW-1:0] rd_idx,
   input logic [31:0]    rd_data
);
   localparam logic [RIW-1:0] RLIM = RIW'(NUM_DWORDS);
   logic oob_wr;
   assign oob_wr = wr_valid && (wr_addr[AW-1:2] >= RLIM);

   assert_ident_R1: assert property (@(posedge clk) disable iff (rst)
      (rd_idx == '0) |=> (rd_data == {DEVICE_ID, VENDOR_ID}));

   assert_oob_read_R2: assert property (@(posedge clk) disable iff (rst)
      (rd_idx >= RLIM) |=> (rd_data == 32'hFFFF_FFFF));

   assert_status_ro_R4: assert property (@(posedge clk) disable iff (rst)
      (rd_idx == RIW'(1)) |=> (rd_data[31:21] == '0 && rd_data[19:16] == '0));

   assert_cap_set_R5: assert property (@(posedge clk) disable iff (rst)
      (cap_present ##1 (rd_idx == RIW'(1))) |=> rd_data[20]);

   assert_err_pulse_R11: assert property (@(posedge clk) disable iff (rst)
      oob_wr |=> wr_err);

   assert_err_quiet_R11: assert property (@(posedge clk) disable iff (rst)
      !oob_wr |=> !wr_err);
endmodule

bind cfg_space_regfile cfg_space_checker #(
   .NUM_DWORDS(NUM_DWORDS),
   .VENDOR_ID (VENDOR_ID),
   .DEVICE_ID (DEVICE_ID)
) u_checker (
   .clk        (clk),
   .rst        (rst),
   .cap_present(cap_present),
   .wr_valid   (wr_valid),
   .wr_addr    (wr_addr),
   .wr_err     (wr_err),
   .rd_idx     (rd_idx),
   .rd_data    (rd_data)
);

// File: tb/test_cfg_space_regfile.sv
`timescale 1ns/1ps
module test_cfg_space_regfile;
   import cfgspace_pkg::*;

   localparam int NDW = 1024;
   localparam int AW  = $clog2(NDW) + 3;
   localparam int RIW = $clog2(NDW) + 1;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           cap_present = 1'b0;
   logic           wr_valid = 1'b0;
   logic [AW-1:0]  wr_addr = '0;
   logic [1:0]     wr_size = '0;
   logic [31:0]    wr_data = '0;
   logic [RIW-1:0] rd_idx = '0;
   logic           err_ep, err_br;
   logic [31:0]    rd_ep, rd_br;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   cfg_space_regfile #(
      .NUM_DWORDS(NDW), .HDR_KIND(HDR_ENDPOINT),
      .VENDOR_ID(16'hA5C3), .DEVICE_ID(16'h7E21), .REVISION(8'h3C),
      .CLASS_CODE(8'h02), .SUBCLASS(8'h80), .PROG_IF(8'h11),
      .SUBSYS_VENDOR(16'h5D10), .SUBSYS_ID(16'h0BEE),
      .INT_PIN(2), .INT_LINE(8'h0B)
   ) i_cfg_space_regfile (
      .clk(clk), .rst(rst), .cap_present(cap_present), .wr_valid(wr_valid),
      .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
      .wr_err(err_ep), .rd_idx(rd_idx), .rd_data(rd_ep)
   );

   cfg_space_regfile #(
      .NUM_DWORDS(NDW), .HDR_KIND(HDR_BRIDGE),
      .VENDOR_ID(16'hA5C3), .DEVICE_ID(16'h7E21), .REVISION(8'h3C),
      .CLASS_CODE(8'h02), .SUBCLASS(8'h80), .PROG_IF(8'h11),
      .SUBSYS_VENDOR(16'h5D10), .SUBSYS_ID(16'h0BEE),
      .INT_PIN(2), .INT_LINE(8'h0B)
   ) i_cfg_space_regfile_bridge (
      .clk(clk), .rst(rst), .cap_present(cap_present), .wr_valid(wr_valid),
      .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
      .wr_err(err_br), .rd_idx(rd_idx), .rd_data(rd_br)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
      end
   endtask

   task automatic do_write(input int addr, input logic [1:0] size,
                           input logic [31:0] data, output logic e_ep, output logic e_br);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = AW'(addr); wr_size = size; wr_data = data;
      @(negedge clk);
      e_ep = err_ep; e_br = err_br;
      wr_valid = 1'b0;
   endtask

   task automatic wr(input int addr, input logic [1:0] size, input logic [31:0] data);
      logic a, b;
      do_write(addr, size, data, a, b);
   endtask

   task automatic rd_both(input int idx, input string req,
                          input logic [31:0] exp_ep, input logic [31:0] exp_br);
      @(negedge clk);
      rd_idx = RIW'(idx);
      @(negedge clk);
      check(req, $sformatf("endpoint dword %0d", idx), rd_ep, exp_ep);
      check(req, $sformatf("bridge dword %0d", idx), rd_br, exp_br);
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_reset_state();
      rd_both(0,  "R1", 32'h7E21A5C3, 32'h7E21A5C3);
      rd_both(2,  "R1", 32'h0280113C, 32'h0280113C);
      rd_both(11, "R1", 32'h0BEE5D10, 32'h0BEE5D10);
      rd_both(1,  "R4", 32'h0, 32'h0);
      rd_both(3,  "R6", 32'h0, 32'h00010000);
      rd_both(15, "R9", 32'h0000030B, 32'h0000030B);
      rd_both(9,  "R10", 32'h0, 32'h0);
      rd_both(5,  "R2", 32'h0, 32'h0);
   endtask

   task automatic t_full_writes();
      wr(32'h0C, 2'd3, 32'h0000005A);        // R3 code 3 dropped
      rd_both(3, "R3", 32'h0, 32'h00010000);
      wr(32'h04, 2'd2, 32'hFFFFFFFF);
      rd_both(1, "R4", 32'h0000FFFF, 32'h0000FFFF);
      wr(32'h00, 2'd2, 32'hFFFFFFFF);
      rd_both(0, "R1", 32'h7E21A5C3, 32'h7E21A5C3);
      wr(32'h2C, 2'd2, 32'h0);
      rd_both(11, "R1", 32'h0BEE5D10, 32'h0BEE5D10);
      wr(32'h0C, 2'd2, 32'hFFFFFFFF);
      rd_both(3, "R6", 32'h000000FF, 32'h000100FF);
      wr(32'h05, 2'd2, 32'h0);               // R3 misaligned full dropped
      rd_both(1, "R3", 32'h0000FFFF, 32'h0000FFFF);
   endtask

   task automatic t_half_writes();
      logic a, b;
      wr(32'h06, 2'd1, 32'h0000FFFF);
      rd_both(1, "R4", 32'h0000FFFF, 32'h0000FFFF);
      do_write(32'h04, 2'd1, 32'hEEEE1234, a, b);
      check("R11", "no error on in-range write", {31'h0, a | b}, 32'h0);
      rd_both(1, "R7", 32'h00001234, 32'h00001234);
      wr(32'h05, 2'd1, 32'h0);
      rd_both(1, "R7", 32'h00001234, 32'h00001234);
      wr(32'h3E, 2'd1, 32'h0000ABCD);
      rd_both(15, "R7", 32'h0000030B, 32'hABCD030B);
   endtask

   task automatic t_byte_writes();
      wr(32'h05, 2'd0, 32'hFFFFFF56);
      rd_both(1, "R8", 32'h00005634, 32'h00005634);
      wr(32'h3D, 2'd0, 32'h000000FF);
      rd_both(15, "R9", 32'h0000030B, 32'hABCD030B);
      wr(32'h3C, 2'd0, 32'h00000077);
      rd_both(15, "R8", 32'h00000377, 32'hABCD0377);
      wr(32'h3F, 2'd0, 32'h0000009A);
      rd_both(15, "R9", 32'h00000377, 32'h9ACD0377);
   endtask

   task automatic t_window();
      wr(32'h24, 2'd2, 32'hFFFFFFFF);
      rd_both(9, "R10", 32'h0, 32'hFFF0FFF0);
   endtask

   task automatic t_out_of_range();
      logic a, b;
      do_write(32'h1004, 2'd2, 32'h0, a, b);
      check("R11", "endpoint wr_err pulse", {31'h0, a}, 32'h1);
      check("R11", "bridge wr_err pulse", {31'h0, b}, 32'h1);
      @(negedge clk);
      check("R11", "wr_err falls", {31'h0, err_ep | err_br}, 32'h0);
      rd_both(1, "R11", 32'h00005634, 32'h00005634);
      rd_both(1024, "R2", 32'hFFFFFFFF, 32'hFFFFFFFF);
      rd_both(2047, "R2", 32'hFFFFFFFF, 32'hFFFFFFFF);
   endtask

   task automatic t_cap();
      @(negedge clk); cap_present = 1'b1;
      @(negedge clk); cap_present = 1'b0;
      rd_both(1, "R5", 32'h00105634, 32'h00105634);
      wr(32'h04, 2'd2, 32'h0);
      rd_both(1, "R5", 32'h00100000, 32'h00100000);
   endtask

   task automatic t_reset_again();
      do_reset();
      rd_both(1,  "R12", 32'h0, 32'h0);
      rd_both(3,  "R12", 32'h0, 32'h00010000);
      rd_both(9,  "R12", 32'h0, 32'h0);
      rd_both(15, "R12", 32'h0000030B, 32'h0000030B);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      t_reset_state();
      t_full_writes();
      t_half_writes();
      t_byte_writes();
      t_window();
      t_out_of_range();
      t_cap();
      t_reset_again();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule